// File: doc/BRIEF.md
# Stack-Pointer Signed-Offset Unit

This unit is the stack-pointer slice of a small 8-bit processor datapath. It holds the 16-bit stack pointer, a 16-bit result pair and the 8-bit condition-flag byte. It runs three multi-cycle operations on request. The first adds a signed 8-bit immediate to the stack pointer and puts the sum in the result pair. The second copies the result pair into the stack pointer. The third writes the stack pointer to memory one byte at a time, starting at a supplied 16-bit address.

The instruction decoder has already fetched the immediate and the address. It presents them together with a 2-bit operation code and a one-cycle `start` strobe. The unit reports that it is running on `busy`. When the operation's cycle budget runs out it gives one `done` pulse. The result, the flags and the stack pointer are registered and keep their values until a later operation changes them. A load strobe from the register file can preload the stack pointer while the unit is idle.

The flag rule for the offset add is deliberately narrow. Half-carry and carry come from adding the raw immediate byte, unsigned, to the low nibble and the low byte of the stack pointer. The sign of the offset and the upper result byte play no part. Zero and subtract are always cleared.

Top module: `sp_offset_unit`

## Requirements
- R1: A synchronous active-high `rst` sets the stack pointer to 0xFFFE, the result pair to 0x0000 and the flag byte to 0x00, and drives `busy`, `done` and `mem_we` low.
- R2: The offset operation (`op`=0) sets the result pair to the stack pointer plus the sign-extended immediate, modulo 2^16. The stack pointer is left as it was.
- R3: The flag byte places half-carry at bit 5 and carry at bit 4. After an offset operation bits 7 (zero) and 6 (subtract) are 0, and bits 3..0 always read 0.
- R4: Half-carry is the carry out of SP[3:0] + imm[3:0]. Carry is the carry out of SP[7:0] + imm[7:0]. Both sums treat the immediate byte as unsigned, even when the offset is negative.
- R5: The copy operation (`op`=1) loads the stack pointer from the result pair and leaves the result pair and all flags unchanged.
- R6: The store operation (`op`=2) raises `mem_we` for exactly two consecutive cycles. The first cycle carries address nn with SP[7:0]. The second carries nn+1 (modulo 2^16) with SP[15:8]. The store changes no register.
- R7: `done` goes high for one cycle exactly N rising edges after the edge that accepts `start`, where N is 12, 8 or 20 for the offset, copy and store operations. `busy` is high from the edge after acceptance until `done` rises.
- R8: `start` is ignored while `busy` is high, and a `start` with `op`=3 starts nothing.
- R9: When the unit is idle and `start` is low, `sp_wr` loads `sp_in` into the stack pointer at the next edge. `sp_wr` is ignored while `busy` or `start` is high.
- R10: The result pair and the flag byte hold their values between operations, including through operations that do not write them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation request |
| op | input | 2 | 0 offset add, 1 copy result to SP, 2 store SP, 3 none |
| imm | input | 8 | Signed offset byte |
| st_addr | input | 16 | Store base address nn |
| sp_wr | input | 1 | Stack-pointer load strobe |
| sp_in | input | 16 | Stack-pointer load value |
| sp_out | output | 16 | Current stack pointer |
| hl_out | output | 16 | Result pair |
| flags_out | output | 8 | Flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_data | output | 8 | Memory byte data |

## Verification
The assertions assume that `rst` is held for at least two clock edges, so nothing left over from an interrupted operation can look like a completion. They also assume that the store budget leaves room for both byte writes before `done`. The bench always holds reset for several cycles and keeps the default cycle counts. It changes `start`, `sp_wr` and the operand inputs only on falling edges, and it presents operands in the same cycle as `start`. It deliberately pulses `start` and `sp_wr` during `busy` so that the "ignored" paths are exercised within these limits.

// File: rtl/sp_ofs_pkg.sv
package sp_ofs_pkg;

    typedef enum logic [1:0] {
        OP_OFS   = 2'd0,
        OP_COPY  = 2'd1,
        OP_STORE = 2'd2,
        OP_NONE  = 2'd3
    } sp_op_e;

    localparam int FLAG_W   = 8;
    localparam int FL_ZERO  = 7;
    localparam int FL_SUB   = 6;
    localparam int FL_HALF  = 5;
    localparam int FL_CARRY = 4;

    function automatic logic [FLAG_W-1:0] pack_flags(input logic z, input logic n,
                                                     input logic h, input logic c);
        logic [FLAG_W-1:0] f;
        f = '0;
        f[FL_ZERO]  = z;
        f[FL_SUB]   = n;
        f[FL_HALF]  = h;
        f[FL_CARRY] = c;
        return f;
    endfunction

endpackage

// File: rtl/sp_ofs_adder.sv
module sp_ofs_adder #(
    parameter int SP_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic [SP_W-1:0]  sp,
    input  logic [OFF_W-1:0] off,
    output logic [SP_W-1:0]  sum,
    output logic             half_c,
    output logic             byte_c
);
    localparam int EXT_W = SP_W - OFF_W;
    localparam int NIB_W = 4;

    logic [NIB_W:0] nib_sum;
    logic [OFF_W:0] low_sum;

    always_comb begin
        sum     = sp + {{EXT_W{off[OFF_W-1]}}, off};
        nib_sum = {1'b0, sp[NIB_W-1:0]} + {1'b0, off[NIB_W-1:0]};
        low_sum = {1'b0, sp[OFF_W-1:0]} + {1'b0, off};
        half_c  = nib_sum[NIB_W];
        byte_c  = low_sum[OFF_W];
    end

endmodule

// File: rtl/sp_ofs_seq.sv
module sp_ofs_seq
    import sp_ofs_pkg::*;
#(
    parameter int OFS_CYC   = 12,
    parameter int COPY_CYC  = 8,
    parameter int STORE_CYC = 20
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  sp_op_e op,
    output logic   busy,
    output logic   accept,
    output logic   last,
    output logic   wr_lo,
    output logic   wr_hi,
    output sp_op_e op_cur
);
    localparam int MAX_A = (OFS_CYC > COPY_CYC) ? OFS_CYC : COPY_CYC;
    localparam int MAX_C = (MAX_A > STORE_CYC) ? MAX_A : STORE_CYC;
    localparam int CNT_W = (MAX_C > 2) ? $clog2(MAX_C) : 2;

    typedef struct packed {
        logic             busy;
        sp_op_e           op;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t q, d;

    function automatic logic [CNT_W-1:0] budget(input sp_op_e o);
        case (o)
            OP_OFS:   return CNT_W'(OFS_CYC - 1);
            OP_COPY:  return CNT_W'(COPY_CYC - 1);
            default:  return CNT_W'(STORE_CYC - 1);
        endcase
    endfunction

    always_comb begin
        accept = !q.busy && start && (op != OP_NONE);
        last   = q.busy && (q.cnt == '0);
        wr_lo  = q.busy && (q.op == OP_STORE) && (q.cnt == CNT_W'(2));
        wr_hi  = q.busy && (q.op == OP_STORE) && (q.cnt == CNT_W'(1));
        d = q;
        if (accept) begin
            d.busy = 1'b1;
            d.op   = op;
            d.cnt  = budget(op);
        end else if (last) begin
            d.busy = 1'b0;
        end else if (q.busy) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{busy: 1'b0, op: OP_NONE, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign busy   = q.busy;
    assign op_cur = q.op;

endmodule

// File: rtl/sp_offset_unit.sv
module sp_offset_unit
    import sp_ofs_pkg::*;
#(
    parameter int              SP_W      = 16,
    parameter int              OFF_W     = 8,
    parameter int              ADDR_W    = 16,
    parameter int              OFS_CYC   = 12,
    parameter int              COPY_CYC  = 8,
    parameter int              STORE_CYC = 20,
    parameter logic [SP_W-1:0] SP_RST    = 16'hFFFE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic [OFF_W-1:0]    imm,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic                sp_wr,
    input  logic [SP_W-1:0]     sp_in,
    output logic [SP_W-1:0]     sp_out,
    output logic [SP_W-1:0]     hl_out,
    output logic [FLAG_W-1:0]   flags_out,
    output logic                busy,
    output logic                done,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SP_W/2-1:0]   mem_data
);
    localparam int HALF_W = SP_W / 2;

    typedef struct packed {
        logic [SP_W-1:0]   sp;
        logic [SP_W-1:0]   hl;
        logic [FLAG_W-1:0] flags;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] maddr;
        logic [HALF_W-1:0] mdata;
        logic [OFF_W-1:0]  imm;
        logic [ADDR_W-1:0] nn;
    } unit_t;

    unit_t q, d;

    logic      s_busy, s_accept, s_last, s_wr_lo, s_wr_hi;
    sp_op_e    s_op;
    logic [SP_W-1:0] add_sum;
    logic      add_h, add_c;

    sp_ofs_seq #(
        .OFS_CYC  (OFS_CYC),
        .COPY_CYC (COPY_CYC),
        .STORE_CYC(STORE_CYC)
    ) i_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (sp_op_e'(op)),
        .busy  (s_busy),
        .accept(s_accept),
        .last  (s_last),
        .wr_lo (s_wr_lo),
        .wr_hi (s_wr_hi),
        .op_cur(s_op)
    );

    sp_ofs_adder #(
        .SP_W (SP_W),
        .OFF_W(OFF_W)
    ) i_add (
        .sp    (q.sp),
        .off   (q.imm),
        .sum   (add_sum),
        .half_c(add_h),
        .byte_c(add_c)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.we   = 1'b0;
        if (s_accept) begin
            d.imm = imm;
            d.nn  = st_addr;
        end else if (!s_busy && !start && sp_wr) begin
            d.sp = sp_in;
        end
        if (s_wr_lo) begin
            d.we    = 1'b1;
            d.maddr = q.nn;
            d.mdata = q.sp[HALF_W-1:0];
        end
        if (s_wr_hi) begin
            d.we    = 1'b1;
            d.maddr = q.nn + ADDR_W'(1);
            d.mdata = q.sp[SP_W-1:HALF_W];
        end
        if (s_last) begin
            d.done = 1'b1;
            case (s_op)
                OP_OFS: begin
                    d.hl    = add_sum;
                    d.flags = pack_flags(1'b0, 1'b0, add_h, add_c);
                end
                OP_COPY: d.sp = q.hl;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.sp <= SP_RST;
        end else begin
            q <= d;
        end
    end

    assign sp_out    = q.sp;
    assign hl_out    = q.hl;
    assign flags_out = q.flags;
    assign busy      = s_busy;
    assign done      = q.done;
    assign mem_we    = q.we;
    assign mem_addr  = q.maddr;
    assign mem_data  = q.mdata;

endmodule

// File: rtl/sp_offset_unit_chk.sv
module sp_offset_unit_chk #(
    parameter int SP_W   = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        flags_out,
    input logic [SP_W-1:0]   sp_out
);
    AST_FLAG_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst) flags_out[3:0] == 4'h0); // R3
    AST_ZN_CLEAR: assert property (@(posedge clk) disable iff (rst) flags_out[7:6] == 2'b00); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R7
    AST_SP_HELD_BUSY: assert property (@(posedge clk) disable iff (rst) busy |=> (!busy || $stable(sp_out))); // R9
    AST_WR_PAIR: assert property (@(posedge clk) disable iff (rst) $rose(mem_we) |=> (mem_we && mem_addr == $past(mem_addr) + 1'b1)); // R6
    AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (rst) mem_we |-> busy); // R6
endmodule

bind sp_offset_unit sp_offset_unit_chk #(.SP_W(SP_W), .ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .flags_out(flags_out),
    .sp_out   (sp_out)
);

// File: tb/test_sp_offset_unit.sv
`timescale 1ns/1ps
module test_sp_offset_unit;
    localparam int N_OFS = 12, N_COPY = 8, N_STORE = 20;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, sp_wr = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [7:0]  imm = '0;
    logic [15:0] st_addr = '0, sp_in = '0;
    logic [15:0] sp_out, hl_out, mem_addr;
    logic [7:0]  flags_out, mem_data;
    logic        busy, done, mem_we;

    int checks = 0, errors = 0, cyc = 0;
    int wn = 0;
    logic [15:0] wr_addr [4];
    logic [7:0]  wr_data [4];
    int          wr_cyc  [4];

    always #2.5 clk = ~clk;

    sp_offset_unit i_sp_offset_unit (
        .clk(clk), .rst(rst), .start(start), .op(op), .imm(imm), .st_addr(st_addr),
        .sp_wr(sp_wr), .sp_in(sp_in), .sp_out(sp_out), .hl_out(hl_out),
        .flags_out(flags_out), .busy(busy), .done(done), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mem_we && wn < 4) begin
            wr_addr[wn] = mem_addr;
            wr_data[wn] = mem_data;
            wr_cyc[wn]  = cyc;
            wn = wn + 1;
        end
    end

    // {sp, imm, expected result, expected flags}
    localparam logic [47:0] VEC [0:7] = '{
        {16'hFFF8, 8'h08, 16'h0000, 8'h30},
        {16'h0001, 8'hFF, 16'h0000, 8'h30},
        {16'h1000, 8'h80, 16'h0F80, 8'h00},
        {16'h00FF, 8'h01, 16'h0100, 8'h30},
        {16'h1234, 8'h7F, 16'h12B3, 8'h20},
        {16'hC0DE, 8'hF0, 16'hC0CE, 8'h10},
        {16'h0000, 8'hFE, 16'hFFFE, 8'h00},
        {16'hABCD, 8'h00, 16'hABCD, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic load_sp(input logic [15:0] v);
        @(negedge clk); sp_wr = 1'b1; sp_in = v;
        @(negedge clk); sp_wr = 1'b0;
    endtask

    // start, then check done timing exactly (R7)
    task automatic run_op(input logic [1:0] o, input logic [7:0] b, input logic [15:0] a, input int n);
        @(negedge clk); start = 1'b1; op = o; imm = b; st_addr = a;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        chk("R7 busy after accept", busy, 1);
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        chk("R7 no early done", done, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 done on time", {busy, done}, 2'b01);
        @(posedge clk);
        @(negedge clk);
        chk("R7 done single cycle", done, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 sp reset", sp_out, 16'hFFFE);
        chk("R1 hl reset", hl_out, 0);
        chk("R1 flags reset", flags_out, 0);
        chk("R1 outputs idle", {busy, done, mem_we}, 0);

        // offset vector walk: R2 R3 R4
        foreach (VEC[i]) begin
            load_sp(VEC[i][47:32]);
            chk("R9 sp load", sp_out, VEC[i][47:32]);
            run_op(2'd0, VEC[i][31:24], 16'h0, N_OFS);
            chk("R2 result", hl_out, VEC[i][23:8]);
            chk("R2 sp kept", sp_out, VEC[i][47:32]);
            chk("R3 R4 flags", flags_out, VEC[i][7:0]);
        end

        // R5 copy: prepare result 0x0100 with flags 0x30
        load_sp(16'h00FF);
        run_op(2'd0, 8'h01, 16'h0, N_OFS);
        run_op(2'd1, 8'h00, 16'h0, N_COPY);
        chk("R5 sp from result", sp_out, 16'h0100);
        chk("R5 result kept", hl_out, 16'h0100);
        chk("R5 flags kept", flags_out, 8'h30);

        // R6 store, wrapping address
        load_sp(16'hBEEF);
        wn = 0;
        run_op(2'd2, 8'h00, 16'hFFFF, N_STORE);
        chk("R6 write count", wn, 2);
        chk("R6 low addr", wr_addr[0], 16'hFFFF);
        chk("R6 low data", wr_data[0], 8'hEF);
        chk("R6 high addr", wr_addr[1], 16'h0000);
        chk("R6 high data", wr_data[1], 8'hBE);
        chk("R6 consecutive", wr_cyc[1] - wr_cyc[0], 1);
        chk("R6 sp kept", sp_out, 16'hBEEF);
        chk("R10 result held", hl_out, 16'h0100);
        chk("R10 flags held", flags_out, 8'h30);

        // R8 start during busy and R9 sp_wr during busy ignored
        load_sp(16'h2000);
        @(negedge clk); start = 1'b1; op = 2'd0; imm = 8'h10;
        @(negedge clk); start = 1'b1; op = 2'd1; sp_wr = 1'b1; sp_in = 16'h7777;
        @(negedge clk); start = 1'b0; sp_wr = 1'b0;
        chk("R9 sp_wr ignored busy", sp_out, 16'h2000);
        wait (done === 1'b1);
        @(negedge clk);
        repeat (N_COPY + 3) @(negedge clk);
        chk("R8 busy start ignored", sp_out, 16'h2000);
        chk("R8 no second op", {busy, done}, 0);
        chk("R2 result", hl_out, 16'h2010);

        // R8 op 3 starts nothing; R9 sp_wr with start ignored
        @(negedge clk); start = 1'b1; op = 2'd3; sp_wr = 1'b1; sp_in = 16'h5555;
        @(negedge clk); start = 1'b0; sp_wr = 1'b0;
        chk("R8 op3 no busy", busy, 0);
        chk("R9 sp_wr with start ignored", sp_out, 16'h2000);
        repeat (N_STORE + 2) @(negedge clk);
        chk("R8 op3 no done", done, 0);
        chk("R10 flags held", flags_out, 8'h00);

        // R1 reset during an operation
        @(negedge clk); start = 1'b1; op = 2'd2; st_addr = 16'h1234;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 sp after reset", sp_out, 16'hFFFE);
        chk("R1 hl after reset", hl_out, 0);
        chk("R1 idle after reset", {busy, done, mem_we, flags_out}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule